// File: doc/BRIEF.md
# Daisy-chain ADC read controller

This block is the host side of a chain of serial converters that share one conversion-start line and one serial clock, with the data output of each converter feeding the data input of the next. The data output of the last converter returns to the host on a single line. That line carries both the end-of-conversion interrupt and the serial data. On a start request, the controller raises the conversion-start line while the serial clock is held high. The clock must be high at that moment so that the converters produce a busy indicator. The controller then waits for the returned line to rise, which marks the end of conversion in every converter.

After that edge, the controller runs the serial clock with a half period of `HALF_DIV` system clocks and shifts in every result bit. It then lowers conversion-start, leaves the clock high, and pulses `done` for one cycle. The results are presented as `N_DEV` words of `WORD_W` bits, indexed by position in the chain.

Two capture modes are selected with `mode3` at start:
- In falling-edge mode, the line is sampled as the clock falls. The first sample is the busy indicator and is discarded.
- In mode-3 style, the line is sampled as the clock rises. The busy indicator is never clocked in.

If no interrupt edge arrives within `TIMEOUT` cycles, the controller pulses an error and returns to idle.

Top module: `daisy_adc_reader`

## Requirements
- R1: After reset, `convst` is 0, `sclk` is 1, and `done` and `tmo_err` are 0.
- R2: A `start` in idle raises `convst` one cycle later with `sclk` at 1. `sclk` then stays at 1 until a 0-to-1 transition is seen on `sdi`.
- R3: `convst` stays at 1 from start until the last bit has been taken in. It falls in the same cycle that `done` is 1.
- R4: In falling-edge mode (`mode3`=0), exactly 16·N_DEV+1 falling edges of `sclk` are generated per read. The sample taken at the first falling edge is not stored.
- R5: In mode-3 style (`mode3`=1), exactly 16·N_DEV falling edges are generated. `sdi` is sampled at the rising edges only, so the busy indicator is never stored.
- R6: The first word received, MSB first, is the one from the last device in the chain (index N_DEV-1). The next word comes from index N_DEV-2, and so on. `words[16·d +: 16]` holds the word of device d.
- R7: `done` is a single-cycle pulse. From that cycle onward, `sclk` is 1 and `convst` is 0.
- R8: If no rise on `sdi` arrives within TIMEOUT cycles of entering the wait, `tmo_err` pulses for one cycle, TIMEOUT+1 cycles after `start`. At the same time `convst` falls, no `sclk` edge is made and `done` stays 0.
- R9: During a read, every `sclk` level lasts exactly HALF_DIV system clock cycles.
- R10: `start` has no effect while a read is in progress. No second read follows, and `convst` stays 0 after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request one conversion and read |
| mode3 | input | 1 | 1: capture on rising edges and skip the busy bit; 0: capture on falling edges |
| sdi | input | 1 | Returned data line, also the end-of-conversion interrupt |
| convst | output | 1 | Shared conversion-start line |
| sclk | output | 1 | Shared serial clock, idle high |
| done | output | 1 | One-cycle pulse when all words are valid |
| tmo_err | output | 1 | One-cycle pulse on interrupt timeout |
| words | output | N_DEV·WORD_W | Result words, device d at bits 16·d upward |

## Verification
The bench uses three chained converter models, `HALF_DIV`=2 and `TIMEOUT`=64.
- Three devices bring both chain hand-overs and the reversed word order within reach of the checks.
- The short half period puts each capture only one system clock after the model updates its output, which is the tightest sampling the design permits.
- The small timeout lets a dead chain expire quickly, while random conversion delays of up to 30 cycles still complete.
- Random values in both capture modes are mixed with all-ones, all-zeros and single-end-bit patterns, so a one-bit slip from a stored busy bit shows up in the words.

// File: rtl/daisy_adc_reader.sv
module daisy_adc_reader #(
  parameter int N_DEV    = 3,
  parameter int WORD_W   = 16,
  parameter int HALF_DIV = 2,
  parameter int TIMEOUT  = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    mode3,
  input  logic                    sdi,
  output logic                    convst,
  output logic                    sclk,
  output logic                    done,
  output logic                    tmo_err,
  output logic [N_DEV*WORD_W-1:0] words
);
  localparam int TOT   = N_DEV * WORD_W;
  localparam int TOG_W = $clog2(2 * TOT + 3);
  localparam int DIV_W = $clog2(HALF_DIV + 1);
  localparam int TO_W  = $clog2(TIMEOUT + 1);

  typedef enum logic [1:0] {IDLE, CONV, SHIFT} st_t;

  st_t              st;
  logic             m3, sdi_q;
  logic [DIV_W-1:0] div_cnt;
  logic [TOG_W-1:0] tog;
  logic [TO_W-1:0]  to_cnt;
  logic [TOT-1:0]   sr;

  wire [TOG_W-1:0] last_tog = m3 ? TOG_W'(2 * TOT) : TOG_W'(2 * TOT + 2);
  wire [TOG_W-1:0] t_next   = tog + 1'b1;
  wire             half_end = (div_cnt == DIV_W'(HALF_DIV - 1));
  wire             capture  = m3 ? !t_next[0] : (t_next[0] && t_next != TOG_W'(1));
  wire [TOT-1:0]   sr_nx    = capture ? {sr[TOT-2:0], sdi} : sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      m3      <= 1'b0;
      sdi_q   <= 1'b0;
      div_cnt <= '0;
      tog     <= '0;
      to_cnt  <= '0;
      sr      <= '0;
      convst  <= 1'b0;
      sclk    <= 1'b1;
      done    <= 1'b0;
      tmo_err <= 1'b0;
      words   <= '0;
    end else begin
      sdi_q   <= sdi;
      done    <= 1'b0;
      tmo_err <= 1'b0;
      case (st)
        IDLE: if (start) begin
          convst <= 1'b1;
          m3     <= mode3;
          to_cnt <= '0;
          st     <= CONV;
        end
        CONV: begin
          if (sdi && !sdi_q) begin
            div_cnt <= '0;
            tog     <= '0;
            st      <= SHIFT;
          end else if (to_cnt == TO_W'(TIMEOUT - 1)) begin
            tmo_err <= 1'b1;
            convst  <= 1'b0;
            st      <= IDLE;
          end else begin
            to_cnt <= to_cnt + 1'b1;
          end
        end
        SHIFT: begin
          if (half_end) begin
            div_cnt <= '0;
            sclk    <= ~sclk;
            tog     <= t_next;
            sr      <= sr_nx;
            if (t_next == last_tog) begin
              words  <= sr_nx;
              convst <= 1'b0;
              done   <= 1'b1;
              st     <= IDLE;
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  AST_CONVST_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(convst) |-> sclk) else $error("convst rose with sclk low"); // R2
  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st != SHIFT) |-> sclk) else $error("sclk low outside read"); // R2
  AST_CONVST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SHIFT) |-> convst) else $error("convst dropped during read"); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R7
  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |-> (!done && !convst)) else $error("timeout with done or convst"); // R8
  AST_TOG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SHIFT) |-> (tog < last_tog)) else $error("edge count overrun"); // R4
  AST_SCLK_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != $past(sclk)) |-> ($past(div_cnt) == DIV_W'(HALF_DIV - 1)))
    else $error("sclk half period wrong"); // R9
endmodule

// File: tb/sim_daisy_adc_reader.sv
module sim_daisy_adc_reader;
  localparam int N  = 3;
  localparam int W  = 16;
  localparam int HD = 2;
  localparam int TO = 64;
  localparam int TOT = N * W;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode3 = 1'b0;
  logic convst, sclk, done, tmo_err, sdi;
  logic [TOT-1:0] words;

  daisy_adc_reader #(.N_DEV(N), .WORD_W(W), .HALF_DIV(HD), .TIMEOUT(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode3(mode3), .sdi(sdi),
    .convst(convst), .sclk(sclk), .done(done), .tmo_err(tmo_err), .words(words));

  always #2 clk = ~clk;

  logic [15:0] vals [N];
  logic [15:0] msr  [N];
  logic        mbusy [N];
  logic [N-1:0] dout;
  logic alive = 1'b1, armed = 1'b0, convst_d = 1'b0, sclk_d = 1'b1, gap_valid = 1'b0;
  int conv_cyc = 10, conv_left = 0, falls = 0, bad_gaps = 0, gap = 0, cyc = 0;
  int errors = 0, checks = 0;
  bit finished = 0;

  for (genvar d = 0; d < N; d++) begin : g_m
    assign dout[d] = mbusy[d] ? 1'b1 : msr[d][15];
  end
  assign sdi = dout[N-1];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    convst_d <= convst;
    sclk_d <= sclk;
    if (sclk_d && !sclk) falls <= falls + 1;
    if (sclk != sclk_d) begin
      if (gap_valid && gap != HD) bad_gaps <= bad_gaps + 1;
      gap_valid <= 1'b1;
      gap <= 1;
    end else begin
      gap <= gap + 1;
      if (!convst) gap_valid <= 1'b0;
    end
    if (!convst) begin
      armed <= 1'b0;
      for (int d = 0; d < N; d++) begin msr[d] <= '0; mbusy[d] <= 1'b0; end
    end else begin
      if (!convst_d) begin
        armed <= sclk && alive;
        conv_left <= conv_cyc;
      end else if (armed) begin
        if (conv_left == 0) begin
          armed <= 1'b0;
          for (int d = 0; d < N; d++) begin msr[d] <= vals[d]; mbusy[d] <= 1'b1; end
        end else conv_left <= conv_left - 1;
      end
      if (sclk_d && !sclk) begin
        for (int d = 0; d < N; d++) begin
          if (mbusy[d]) mbusy[d] <= 1'b0;
          else msr[d] <= {msr[d][14:0], (d == 0) ? convst : dout[(d == 0) ? 0 : d-1]};
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [TOT-1:0] exp_words();
    logic [TOT-1:0] r;
    for (int d = 0; d < N; d++) r[16*d +: 16] = vals[d];
    return r;
  endfunction

  function automatic int exp_falls(input bit m);
    return m ? 16 * N : 16 * N + 1;
  endfunction

  task automatic do_read(input bit m, input bit poke);
    int f0, b0, n;
    bit seen;
    f0 = falls; b0 = bad_gaps; seen = 0;
    @(negedge clk); mode3 = m; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(convst === 1'b1 && sclk === 1'b1, "R2 convst up with sclk high", {convst, sclk}, 2'b11);
    for (n = 0; n < 5000; n++) begin
      if (done) begin seen = 1; break; end
      if (poke && n == 40) start = 1'b1; else start = 1'b0;
      if (n > 0 && !done) begin
        if (convst !== 1'b1) begin
          check(1'b0, "R3 convst held during read", convst, 1); break;
        end
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(seen, "R3 done reached", seen, 1);
    check(words === exp_words(), "R6 words order", words, exp_words());
    check(convst === 1'b0 && sclk === 1'b1, "R7 lines after done", {convst, sclk}, 2'b01);
    check(falls - f0 == exp_falls(m), m ? "R5 falling edges mode3" : "R4 falling edges",
          falls - f0, exp_falls(m));
    check(bad_gaps == b0, "R9 half period", bad_gaps - b0, 0);
    @(negedge clk);
    check(done === 1'b0, "R7 done single pulse", done, 0);
    if (poke) begin
      repeat (10) @(negedge clk);
      check(convst === 1'b0 && falls - f0 == exp_falls(m), "R10 start ignored during read",
            {convst, 8'(falls - f0)}, {1'b0, 8'(exp_falls(m))});
    end
  endtask

  task automatic set_vals(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
    vals[0] = a; vals[1] = b; vals[2] = c;
  endtask

  initial begin
    int n;
    void'($urandom(32'd4242));
    set_vals(16'h0, 16'h0, 16'h0);
    repeat (3) @(negedge clk);
    check(convst === 1'b0 && sclk === 1'b1 && done === 1'b0 && tmo_err === 1'b0,
          "R1 reset state", {convst, sclk, done, tmo_err}, 4'b0100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(convst === 1'b0 && sclk === 1'b1, "R1 idle after reset", {convst, sclk}, 2'b01);

    set_vals(16'hFFFF, 16'hFFFF, 16'hFFFF); do_read(1'b0, 1'b0);
    set_vals(16'hFFFF, 16'hFFFF, 16'hFFFF); do_read(1'b1, 1'b0);
    set_vals(16'h0000, 16'h0000, 16'h0000); do_read(1'b0, 1'b0);
    set_vals(16'h8001, 16'h0001, 16'h8000); do_read(1'b1, 1'b0);
    set_vals(16'h8001, 16'h0001, 16'h8000); do_read(1'b0, 1'b0);
    set_vals(16'h1234, 16'hABCD, 16'h0F0F); do_read(1'b0, 1'b1);
    for (int i = 0; i < 8; i++) begin
      set_vals(16'($urandom), 16'($urandom), 16'($urandom));
      conv_cyc = 3 + int'($urandom_range(0, 27));
      do_read(1'($urandom), 1'b0);
    end

    alive = 1'b0;
    @(negedge clk); start = 1'b1; mode3 = 1'b0;
    n = falls;
    @(negedge clk); start = 1'b0;
    begin
      int j; bit got;
      j = 1; got = 0;
      while (j < 200) begin
        if (done) check(1'b0, "R8 no done on timeout", done, 0);
        if (tmo_err) begin got = 1; break; end
        @(negedge clk); j++;
      end
      check(got && j == TO + 1, "R8 timeout cycle", j, TO + 1);
      check(convst === 1'b0 && falls == n, "R8 lines on timeout", {convst, 8'(falls - n)}, 9'h0);
      @(negedge clk);
      check(tmo_err === 1'b0, "R8 error single pulse", tmo_err, 0);
    end
    alive = 1'b1;
    conv_cyc = 7;
    set_vals(16'h5A5A, 16'hC3C3, 16'h7E81); do_read(1'b1, 1'b0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule